// File: doc/BRIEF.md
# Bus Cycle Priority Arbiter

This block sits inside a processor bus interface and decides which internal source gets the next cycle on the shared external bus. There are six requesters. In falling priority they are internal-error interrupt vectoring, hardware interrupt vectoring, coprocessor-error vectoring, DMA transfers, general instruction execution and prefetch-queue fill. Only one bus cycle is granted at a time. The grant stays in place until the bus engine pulses `done`.

Each requester drives three signals:
- a request bit;
- a continuation flag, which says its next cycle must follow with no gap (for example the second half of a word split across an odd address);
- a lock flag.

When a requester wins normal arbitration with its lock flag raised, it becomes the owner of the bus. It keeps the bus over every other source until it drops the lock at the end of one of its cycles. Cycles without continuation or lock, such as load/store pairs or string steps, compete afresh at every cycle boundary. Cycles from other sources can therefore slip in between them.

Top module: `bus_cycle_arbiter`

## Requirements
- R1: After reset no grant is asserted, no owner is held and nothing is locked.
- R2: Requester index sets the priority. Bit 0 is internal-error vectoring (highest), bit 1 hardware interrupt, bit 2 coprocessor error, bit 3 DMA, bit 4 instruction execution and bit 5 prefetch fill (lowest). With no owner, the lowest set request index wins.
- R3: `grant` is one-hot or zero. It is registered: the requests present at a clock edge where the bus is idle or `done` is high decide the grant visible after that edge.
- R4: A grant holds, unchanged, until a `done` pulse. Request, continuation and lock changes in mid-cycle do not alter it.
- R5: If the granted requester has its continuation bit high when `done` arrives, its next cycle is granted straight away, even over higher-priority requests.
- R6: If the granted requester has continuation low (and is not locked) at `done`, a higher-priority request is served before its next cycle.
- R7: A requester that wins normal arbitration with its lock bit high keeps the bus over all others. Ownership ends only when its lock bit is low at one of its `done` pulses.
- R8: A lock bit raised by a requester that does not win arbitration has no effect. No lock is recorded, and the winner is not made an owner.
- R9: A request dropped before the boundary edge is not granted at that edge. Raising it again later is served normally.
- R10: Prefetch fill (bit 5) is granted only when no other bit requests.
- R11: While an owner is held but is not requesting, the bus stays idle (grant zero) even if other sources request. The owner's next request is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NREQ | Request bits, bit 0 highest priority |
| cont | input | NREQ | Continuation flags: next cycle must follow unbroken |
| lock | input | NREQ | Lock flags, recognised when that requester wins arbitration |
| done | input | 1 | Pulse marking the end of the granted bus cycle |
| grant | output | NREQ | One-hot grant of the current bus cycle |

## Verification
Every result of this block is a grant, and it is due one clock after the edge that samples the inputs. A new grant follows the first rising edge that sees an idle bus. A replacement grant follows the edge on which `done` is high. A mid-cycle change must show no effect at that same point.

The driver applies each stimulus on a falling edge. Just after the next rising edge it queues the grant that the requirements predict. The monitor pops and compares on the following falling edge, so each comparison lands exactly one register stage after its cause.

// File: rtl/bus_cycle_arbiter.sv
module bus_cycle_arbiter #(
  parameter int NREQ = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic [NREQ-1:0] cont,
  input  logic [NREQ-1:0] lock,
  input  logic            done,
  output logic [NREQ-1:0] grant
);

  logic [NREQ-1:0] grant_q, owner_q, grant_n, owner_n, pick;
  logic            locked_q, locked_n, keep;

  wire busy     = |grant_q;
  wire boundary = !busy || done;

  always_comb begin
    pick = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (req[i]) pick = NREQ'(1) << i;
  end

  assign keep = locked_q ? |(lock & grant_q) : |(cont & grant_q);

  always_comb begin
    if (busy && done) begin
      owner_n  = keep ? grant_q : '0;
      locked_n = locked_q && keep;
    end else begin
      owner_n  = owner_q;
      locked_n = locked_q;
    end
    if (|owner_n) begin
      grant_n = req & owner_n;
    end else begin
      grant_n = pick;
      if (|(lock & pick)) begin
        locked_n = 1'b1;
        owner_n  = pick;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q  <= '0;
      owner_q  <= '0;
      locked_q <= 1'b0;
    end else if (boundary) begin
      grant_q  <= grant_n;
      owner_q  <= owner_n;
      locked_q <= locked_n;
    end
  end

  assign grant = grant_q;

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(grant));

  // R9
  grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (grant == '0) || (|($past(req) & grant)));

  // R5
  atomic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done && !locked_q && |(cont & grant) && |(req & grant))
      |=> grant == $past(grant));

  // R7
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && busy && done && |(lock & grant) && |(req & grant))
      |=> grant == $past(grant));

endmodule

// File: tb/test_bus_cycle_arbiter.sv
module test_bus_cycle_arbiter;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, cont = '0, lock = '0;
  logic done = 1'b0;
  logic [N-1:0] grant;

  int checks = 0, fails = 0, cycles = 0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  bit           stim_done = 1'b0;

  always #2.5 clk = ~clk;

  bus_cycle_arbiter #(.NREQ(N)) i_bus_cycle_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .cont(cont), .lock(lock),
    .done(done), .grant(grant)
  );

  task automatic cyc(input logic [N-1:0] r, input logic [N-1:0] c,
                     input logic [N-1:0] l, input logic d,
                     input logic [N-1:0] e, input string t);
    @(negedge clk);
    req = r; cont = c; lock = l; done = d;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [N-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (grant !== e) begin
        fails++;
        $display("FAIL %s: grant=%b expected=%b", t, grant, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: stalled, actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(6'b000000, 0, 0, 0, 6'b000000, "R1 idle after reset");
    cyc(6'b110000, 0, 0, 0, 6'b010000, "R2 exec over prefetch");
    cyc(6'b110001, 0, 0, 0, 6'b010000, "R4 held mid-cycle");
    cyc(6'b110001, 0, 0, 1, 6'b000001, "R2 internal error wins");
    cyc(6'b110000, 0, 0, 1, 6'b010000, "R2 exec next");
    cyc(6'b100000, 0, 0, 1, 6'b100000, "R10 prefetch alone");
    cyc(6'b000000, 0, 0, 1, 6'b000000, "R3 idle no request");
    cyc(6'b000000, 0, 0, 0, 6'b000000, "R3 stays idle");
    cyc(6'b001000, 0, 0, 0, 6'b001000, "R2 dma");
    cyc(6'b001001, 6'b001000, 0, 1, 6'b001000, "R5 atomic pair kept");
    cyc(6'b001001, 0, 0, 1, 6'b000001, "R6 released to higher");
    cyc(6'b001000, 0, 0, 1, 6'b001000, "R6 dma resumes");
    cyc(6'b001010, 0, 0, 1, 6'b000010, "R6 interleave hw int");
    cyc(6'b001000, 0, 0, 1, 6'b001000, "R6 dma again");
    cyc(6'b000000, 0, 0, 1, 6'b000000, "R3 idle");
    cyc(6'b010000, 0, 6'b010000, 0, 6'b010000, "R7 locked start");
    cyc(6'b010001, 0, 6'b010000, 1, 6'b010000, "R7 lock over ierr");
    cyc(6'b010011, 0, 6'b010000, 1, 6'b010000, "R7 lock without cont");
    cyc(6'b010011, 0, 6'b000000, 1, 6'b000001, "R7 lock released");
    cyc(6'b000010, 0, 0, 1, 6'b000010, "R2 hw int");
    cyc(6'b100010, 0, 6'b100000, 0, 6'b000010, "R4 held with foreign lock");
    cyc(6'b100001, 0, 6'b100000, 1, 6'b000001, "R8 loser lock ignored");
    cyc(6'b100000, 0, 0, 1, 6'b100000, "R8 no owner recorded");
    cyc(6'b101000, 0, 0, 1, 6'b001000, "R10 prefetch not locked");
    cyc(6'b000100, 0, 0, 0, 6'b001000, "R4 held");
    cyc(6'b000000, 0, 0, 1, 6'b000000, "R9 withdrawn not granted");
    cyc(6'b000100, 0, 0, 0, 6'b000100, "R9 later granted");
    cyc(6'b000000, 0, 0, 1, 6'b000000, "R3 idle");
    cyc(6'b010000, 0, 0, 0, 6'b010000, "R2 exec");
    cyc(6'b000010, 6'b010000, 0, 1, 6'b000000, "R11 owner waiting blocks");
    cyc(6'b010010, 0, 0, 0, 6'b010000, "R11 owner resumes");
    cyc(6'b000010, 0, 0, 1, 6'b000010, "R6 after release");
    cyc(6'b000000, 0, 0, 1, 6'b000000, "R3 final idle");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule